// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block is a passive observer placed on the command pins of a four-bank synchronous DRAM interface. On every rising clock edge it decodes the chip-select, row-strobe, column-strobe, write-enable, clock-enable, bank and A10 pins into a command. It keeps a model of which banks hold an open row, whether a write burst is still running, and whether the device is recovering from a write or busy with an auto-refresh. From that model it reports one of four states: idle, active, write-recovering or refreshing.

The monitor checks each command against the rules for the state it arrives in. When a command is not allowed, it raises a one-cycle error pulse in the next cycle, together with a code that names the command and the state. It drives nothing on the memory bus. It is meant for simulation benches and for on-chip debug taps that sit beside a memory controller. Burst length, write recovery time and refresh cycle time are parameters, counted in clock cycles.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: `cmd_o` shows the decoded command in the same cycle as the pins. The codes are:
  - 0 deselect: `cs_n` high; the other pins are ignored.
  - With `cs_n` low, the code depends on `ras_n`,`cas_n`,`we_n`:
    - 1 no-operation: 111.
    - 2 burst terminate: 110.
    - 3 read: 101.
    - 4 write: 100.
    - 5 activate: 011.
    - 6 precharge: 010 with `a10` low.
    - 7 precharge-all: 010 with `a10` high.
    - 8 auto-refresh: 001 with `cke` high.
    - 9 self-refresh entry: 001 with `cke` low.
    - 10 mode register set: 000.
- R2: `state_o` codes are 0 idle, 1 active, 2 write-recovering and 3 refreshing.
  - Idle means no bank is open and no write burst is running.
  - Active means at least one bank is open, or a write burst is running.
  - After reset the state is idle and `err_o` is low.
- R3: A command that is illegal in cycle c makes `err_o` high for cycle c+1 only.
  - In that cycle `err_code_o` = {command code[3:0], state code[1:0]}, using the state at the time of the command.
  - A legal command leaves `err_o` low in cycle c+1.
- R4: In idle, burst terminate, read and write are illegal. All other commands are legal.
- R5: In active, these commands are illegal:
  - auto-refresh, self-refresh entry and mode register set;
  - activate to a bank that is already open;
  - read or write to a bank that is closed.
  All other commands are legal.
- R6: In write-recovering, only deselect and no-operation are legal.
- R7: In refreshing, only deselect and no-operation are legal.
- R8: A legal auto-refresh in cycle t puts the state in refreshing for cycles t+1 to t+T_RC. The state is idle from cycle t+T_RC+1.
- R9: A legal write in cycle t starts a burst of BURST_LEN beats, with the last beat in cycle t+BURST_LEN-1.
  - The state is write-recovering for the T_WR cycles after the last beat.
  - After that it is active if any bank is open, otherwise idle.
- R10: During a write burst, a legal burst terminate, read, precharge or precharge-all ends the burst without write recovery. A legal write during a burst restarts it.
- R11: An illegal command changes no bank, burst or state tracking.
- R12: Bank closing:
  - A legal activate opens the addressed bank.
  - A legal precharge closes the addressed bank.
  - A legal precharge-all closes every bank.
  - A legal read or write with `a10` high closes the addressed bank in that same cycle.
- R13: An illegal command that arrives in the last-beat cycle of a write burst is flagged. Write recovery still begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; pins sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable (refresh option) |
| ba | input | 2 | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all option |
| cmd_o | output | 4 | Decoded command of the current cycle |
| state_o | output | 2 | Tracked device state |
| err_o | output | 1 | One-cycle pulse for an illegal command |
| err_code_o | output | 6 | {command, state} of the offending command |

## Verification
Two functions can fall in the same cycle: finishing a write burst and flagging an illegal command. The bench places an illegal auto-refresh on the final data beat of a write, then a mode register set in the first recovery cycle. It expects two error pulses back to back, with codes that carry the active state and then the write-recovering state. It also expects recovery to last exactly T_WR cycles and no longer. A second overlap is a write that restarts an unfinished burst. In that case recovery must be timed from the later write's last beat.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  localparam int CMD_W  = 4;
  localparam int ST_W   = 2;
  localparam int CODE_W = CMD_W + ST_W;

  typedef enum logic [CMD_W-1:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_PALL  = 4'd7,
    CMD_REF   = 4'd8,
    CMD_SREF  = 4'd9,
    CMD_MRS   = 4'd10
  } cmd_e;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_WRREC   = 2'd2,
    ST_REFRESH = 2'd3
  } mon_state_e;

  typedef enum logic [1:0] {
    PH_NORM = 2'd0,
    PH_WRREC = 2'd1,
    PH_REFR = 2'd2
  } phase_e;

  function automatic logic [CODE_W-1:0] make_code(input cmd_e c, input mon_state_e s);
    return {c, s};
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  input  logic a10,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BST;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdram_cmd_rules.sv
module sdram_cmd_rules
  import sdram_mon_pkg::*;
(
  input  cmd_e       cmd,
  input  mon_state_e state,
  input  logic       bank_is_open,
  output logic       legal
);

  always_comb begin
    unique case (state)
      ST_IDLE: begin
        legal = !(cmd inside {CMD_BST, CMD_READ, CMD_WRITE});
      end
      ST_ACTIVE: begin
        unique case (cmd)
          CMD_ACT:                     legal = !bank_is_open;
          CMD_READ, CMD_WRITE:         legal = bank_is_open;
          CMD_REF, CMD_SREF, CMD_MRS:  legal = 1'b0;
          default:                     legal = 1'b1;
        endcase
      end
      default: begin
        legal = (cmd inside {CMD_DESEL, CMD_NOP});
      end
    endcase
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cmd_e                 cmd,
  input  logic                 legal,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  output logic [NUM_BANKS-1:0] bank_open
);

  logic is_access;
  assign is_access = (cmd == CMD_READ) || (cmd == CMD_WRITE);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel, set_b, clr_b, upd_b, open_d, open_q;

    assign sel   = (ba == BA_W'(g));
    assign set_b = legal && (cmd == CMD_ACT) && sel;
    assign clr_b = legal && (((cmd == CMD_PRE) && sel) ||
                             (cmd == CMD_PALL) ||
                             (is_access && a10 && sel));
    assign upd_b = set_b || clr_b;

    always_comb begin
      open_d = open_q;
      if (set_b)      open_d = 1'b1;
      else if (clr_b) open_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
      end else if (upd_b) begin
        open_q <= open_d;
      end
    end

    assign bank_open[g] = open_q;
  end

endmodule

// File: rtl/sdram_mon_fsm.sv
module sdram_mon_fsm
  import sdram_mon_pkg::*;
#(
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RC      = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cmd_e       cmd,
  input  logic       legal,
  input  logic       any_open,
  output mon_state_e state
);

  localparam int MAX_A = (T_RC > T_WR) ? T_RC : T_WR;
  localparam int MAX_B = (MAX_A > BURST_LEN) ? MAX_A : BURST_LEN;
  localparam int CNT_W = $clog2(MAX_B + 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] tcnt_q, tcnt_d;
  logic             burst_q, burst_d;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;

  logic ends_burst, start_wr, last_beat, start_ref;

  assign start_wr   = legal && (cmd == CMD_WRITE);
  assign start_ref  = legal && (cmd == CMD_REF);
  assign ends_burst = legal && (cmd inside {CMD_BST, CMD_READ, CMD_WRITE, CMD_PRE, CMD_PALL});
  assign last_beat  = (start_wr && (BURST_LEN == 1)) ||
                      (burst_q && (bcnt_q == CNT_W'(1)) && !ends_burst);

  // Write burst beat counter
  always_comb begin
    burst_d = burst_q;
    bcnt_d  = bcnt_q;
    if (start_wr && (BURST_LEN > 1)) begin
      burst_d = 1'b1;
      bcnt_d  = CNT_W'(BURST_LEN - 1);
    end else if (ends_burst || last_beat) begin
      burst_d = 1'b0;
    end else if (burst_q) begin
      bcnt_d = bcnt_q - CNT_W'(1);
    end
  end

  // Phase: normal, write recovery, refresh
  always_comb begin
    phase_d = phase_q;
    tcnt_d  = tcnt_q;
    unique case (phase_q)
      PH_NORM: begin
        if (start_ref) begin
          phase_d = PH_REFR;
          tcnt_d  = CNT_W'(T_RC - 1);
        end else if (last_beat) begin
          phase_d = PH_WRREC;
          tcnt_d  = CNT_W'(T_WR - 1);
        end
      end
      default: begin
        if (tcnt_q == '0) phase_d = PH_NORM;
        else              tcnt_d  = tcnt_q - CNT_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_NORM;
      tcnt_q  <= '0;
      burst_q <= 1'b0;
      bcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      tcnt_q  <= tcnt_d;
      burst_q <= burst_d;
      bcnt_q  <= bcnt_d;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_WRREC: state = ST_WRREC;
      PH_REFR:  state = ST_REFRESH;
      default:  state = (any_open || burst_q) ? ST_ACTIVE : ST_IDLE;
    endcase
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RC      = 6,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [BA_W-1:0]   ba,
  input  logic              a10,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ST_W-1:0]   state_o,
  output logic              err_o,
  output logic [CODE_W-1:0] err_code_o
);

  cmd_e                 cmd_w;
  mon_state_e           state_w;
  logic                 legal_w;
  logic [NUM_BANKS-1:0] bank_open_w;
  logic                 err_q;
  logic [CODE_W-1:0]    code_q;

  sdram_cmd_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .a10   (a10),
    .cmd   (cmd_w)
  );

  sdram_cmd_rules u_rules (
    .cmd          (cmd_w),
    .state        (state_w),
    .bank_is_open (bank_open_w[ba]),
    .legal        (legal_w)
  );

  sdram_bank_tracker #(.NUM_BANKS(NUM_BANKS)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd_w),
    .legal     (legal_w),
    .ba        (ba),
    .a10       (a10),
    .bank_open (bank_open_w)
  );

  sdram_mon_fsm #(
    .BURST_LEN (BURST_LEN),
    .T_WR      (T_WR),
    .T_RC      (T_RC)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd_w),
    .legal    (legal_w),
    .any_open (|bank_open_w),
    .state    (state_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= !legal_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (!legal_w) begin
      code_q <= make_code(cmd_w, state_w);
    end
  end

  assign cmd_o      = cmd_w;
  assign state_o    = state_w;
  assign err_o      = err_q;
  assign err_code_o = code_q;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
  import sdram_mon_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input cmd_e              cmd,
  input mon_state_e        st,
  input logic              err,
  input logic [CODE_W-1:0] code
);

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && (cmd == CMD_READ || cmd == CMD_WRITE || cmd == CMD_BST)) |=> err); // R4

  AST_WRREC_ONLY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRREC && !(cmd == CMD_DESEL || cmd == CMD_NOP)) |=> err); // R6

  AST_REFR_ONLY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REFRESH && !(cmd == CMD_DESEL || cmd == CMD_NOP)) |=> err); // R7

  AST_ERR_NOT_FOR_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (code[CODE_W-1:ST_W] != CMD_DESEL && code[CODE_W-1:ST_W] != CMD_NOP)); // R3

  AST_ERR_STATE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (code[ST_W-1:0] == $past(st))); // R3

  AST_REFR_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REFRESH) |=> (st == ST_REFRESH || st == ST_IDLE)); // R8

  AST_REFR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REFRESH && $past(st) != ST_REFRESH) |-> ($past(st) == ST_IDLE && $past(cmd) == CMD_REF)); // R8

  AST_WRREC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WRREC && $past(st) != ST_WRREC) |-> ($past(st) == ST_ACTIVE)); // R9

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cmd   (cmd_w),
  .st    (state_w),
  .err   (err_o),
  .code  (err_code_o)
);

// File: tb/sdram_cmd_monitor_bench.sv
`timescale 1ns/1ps
module sdram_cmd_monitor_bench;
  import sdram_mon_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       cs_n, ras_n, cas_n, we_n, cke, a10;
  logic [1:0] ba;
  logic [3:0] cmd_o;
  logic [1:0] state_o;
  logic       err_o;
  logic [5:0] err_code_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .a10(a10),
    .cmd_o(cmd_o), .state_o(state_o), .err_o(err_o), .err_code_o(err_code_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input cmd_e c, input logic [1:0] b, input logic a);
    ba = b; a10 = a; cke = 1'b1; cs_n = 1'b0;
    case (c)
      CMD_DESEL: begin cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; end
      CMD_NOP:   {ras_n, cas_n, we_n} = 3'b111;
      CMD_BST:   {ras_n, cas_n, we_n} = 3'b110;
      CMD_READ:  {ras_n, cas_n, we_n} = 3'b101;
      CMD_WRITE: {ras_n, cas_n, we_n} = 3'b100;
      CMD_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      CMD_PRE:   begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b0; end
      CMD_PALL:  begin {ras_n, cas_n, we_n} = 3'b010; a10 = 1'b1; end
      CMD_REF:   {ras_n, cas_n, we_n} = 3'b001;
      CMD_SREF:  begin {ras_n, cas_n, we_n} = 3'b001; cke = 1'b0; end
      default:   {ras_n, cas_n, we_n} = 3'b000;
    endcase
  endtask

  // One command cycle: checks state on arrival, decode, then error pulse
  task automatic step(input cmd_e c, input logic [1:0] b, input logic a,
                      input mon_state_e st, input bit ill, input string req);
    @(negedge clk);
    drive(c, b, a);
    #1;
    chk(state_o == st, req, "state", state_o, st);
    chk(cmd_o == c, "R1", "decode", cmd_o, c);
    @(posedge clk);
    #1;
    chk(err_o == ill, req, "err_o (R3)", err_o, ill);
    if (ill) chk(err_code_o == {c, st}, req, "err_code (R3)", err_code_o, {c, st});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(CMD_NOP, 2'd0, 1'b0);
    repeat (3) @(posedge clk);
    #1;
    chk(state_o == ST_IDLE, "R2", "reset state", state_o, ST_IDLE);
    chk(err_o == 1'b0, "R2", "reset err", err_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_idle_rules();
    step(CMD_BST,   2'd0, 1'b0, ST_IDLE, 1, "R4");
    step(CMD_READ,  2'd0, 1'b0, ST_IDLE, 1, "R4");
    step(CMD_WRITE, 2'd1, 1'b0, ST_IDLE, 1, "R4");
    step(CMD_MRS,   2'd0, 1'b0, ST_IDLE, 0, "R4");
    step(CMD_SREF,  2'd0, 1'b0, ST_IDLE, 0, "R4");
    step(CMD_PALL,  2'd0, 1'b1, ST_IDLE, 0, "R4");
    step(CMD_PRE,   2'd2, 1'b0, ST_IDLE, 0, "R4");
    step(CMD_DESEL, 2'd0, 1'b0, ST_IDLE, 0, "R4");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE, 0, "R4");
  endtask

  task automatic t_active_rules();
    step(CMD_ACT,   2'd0, 1'b0, ST_IDLE,   0, "R12");
    step(CMD_READ,  2'd0, 1'b0, ST_ACTIVE, 0, "R5");
    step(CMD_READ,  2'd1, 1'b0, ST_ACTIVE, 1, "R5");
    step(CMD_WRITE, 2'd1, 1'b0, ST_ACTIVE, 1, "R5");
    step(CMD_ACT,   2'd0, 1'b0, ST_ACTIVE, 1, "R5");
    step(CMD_REF,   2'd0, 1'b0, ST_ACTIVE, 1, "R5");
    step(CMD_MRS,   2'd0, 1'b0, ST_ACTIVE, 1, "R5");
    step(CMD_SREF,  2'd0, 1'b0, ST_ACTIVE, 1, "R5");
    step(CMD_BST,   2'd0, 1'b0, ST_ACTIVE, 0, "R11");
    step(CMD_ACT,   2'd1, 1'b0, ST_ACTIVE, 0, "R5");
    step(CMD_PALL,  2'd0, 1'b1, ST_ACTIVE, 0, "R12");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE,   0, "R12");
  endtask

  task automatic t_write_recovery();
    step(CMD_ACT,   2'd1, 1'b0, ST_IDLE,   0, "R9");
    step(CMD_WRITE, 2'd1, 1'b0, ST_ACTIVE, 0, "R9");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R9");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R9");
    step(CMD_REF,   2'd0, 1'b0, ST_ACTIVE, 1, "R13");
    step(CMD_MRS,   2'd0, 1'b0, ST_WRREC,  1, "R13");
    step(CMD_DESEL, 2'd0, 1'b0, ST_WRREC,  0, "R6");
    step(CMD_PRE,   2'd1, 1'b0, ST_ACTIVE, 0, "R9");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE,   0, "R12");
    // illegal read and activate inside recovery
    step(CMD_ACT,   2'd2, 1'b0, ST_IDLE,   0, "R6");
    step(CMD_WRITE, 2'd2, 1'b0, ST_ACTIVE, 0, "R6");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R6");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R6");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R6");
    step(CMD_READ,  2'd2, 1'b0, ST_WRREC,  1, "R6");
    step(CMD_ACT,   2'd3, 1'b0, ST_WRREC,  1, "R6");
    step(CMD_PRE,   2'd2, 1'b0, ST_ACTIVE, 0, "R11");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE,   0, "R11");
  endtask

  task automatic t_refresh();
    step(CMD_REF,   2'd0, 1'b0, ST_IDLE,    0, "R8");
    step(CMD_ACT,   2'd0, 1'b0, ST_REFRESH, 1, "R7");
    step(CMD_REF,   2'd0, 1'b0, ST_REFRESH, 1, "R7");
    step(CMD_BST,   2'd0, 1'b0, ST_REFRESH, 1, "R7");
    step(CMD_DESEL, 2'd0, 1'b0, ST_REFRESH, 0, "R7");
    step(CMD_NOP,   2'd0, 1'b0, ST_REFRESH, 0, "R7");
    step(CMD_NOP,   2'd0, 1'b0, ST_REFRESH, 0, "R8");
    step(CMD_ACT,   2'd3, 1'b0, ST_IDLE,    0, "R11");
    step(CMD_PRE,   2'd3, 1'b0, ST_ACTIVE,  0, "R12");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE,    0, "R8");
  endtask

  task automatic t_burst_cut();
    step(CMD_ACT,   2'd2, 1'b0, ST_IDLE,   0, "R10");
    step(CMD_WRITE, 2'd2, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_BST,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    // restart: second write two cycles after the first
    step(CMD_WRITE, 2'd2, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_WRITE, 2'd2, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_WRREC,  0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_WRREC,  0, "R10");
    step(CMD_PRE,   2'd2, 1'b0, ST_ACTIVE, 0, "R10");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE,   0, "R10");
  endtask

  task automatic t_auto_precharge();
    step(CMD_ACT,   2'd3, 1'b0, ST_IDLE,   0, "R12");
    step(CMD_WRITE, 2'd3, 1'b1, ST_ACTIVE, 0, "R12");
    step(CMD_READ,  2'd3, 1'b0, ST_ACTIVE, 1, "R12");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R12");
    step(CMD_NOP,   2'd0, 1'b0, ST_ACTIVE, 0, "R12");
    step(CMD_NOP,   2'd0, 1'b0, ST_WRREC,  0, "R9");
    step(CMD_NOP,   2'd0, 1'b0, ST_WRREC,  0, "R9");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE,   0, "R9");
    step(CMD_ACT,   2'd0, 1'b0, ST_IDLE,   0, "R12");
    step(CMD_READ,  2'd0, 1'b1, ST_ACTIVE, 0, "R12");
    step(CMD_READ,  2'd0, 1'b0, ST_IDLE,   1, "R12");
    step(CMD_ACT,   2'd0, 1'b0, ST_IDLE,   0, "R12");
    step(CMD_ACT,   2'd1, 1'b0, ST_ACTIVE, 0, "R12");
    step(CMD_PALL,  2'd0, 1'b1, ST_ACTIVE, 0, "R12");
    step(CMD_NOP,   2'd0, 1'b0, ST_IDLE,   0, "R12");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_rules();
    t_active_rules();
    t_write_recovery();
    t_refresh();
    t_burst_cut();
    t_auto_precharge();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule